// File: doc/BRIEF.md
# Execute Stage with Parked Load

This block is the execute stage of a small single-issue, in-order 64-bit core. Each incoming instruction arrives already decoded, with both operands resolved to values, a sequential next PC and a tag. The stage computes an arithmetic result or a resolved branch target and hands the instruction to writeback on the same cycle it is accepted. Four valid/ready channels connect it to its neighbours: instruction in, writeback out, memory command out and memory response in.

A load is handled in two phases. In the issue phase the stage sends a line-read command to memory and moves the instruction into a one-entry park slot. In the completion phase the stage waits for the line response. It then picks eight bytes of the line, least significant first, starting at the byte offset of the load address, and forwards the load to writeback with that word as its result. A parked load always takes priority over new work.

The control is a two-state machine. In state OPEN the slot is empty and new instructions may be accepted. In state PARKED a load is waiting for its line. Transition ISSUE (OPEN to PARKED) is taken when a load is accepted. Transition COMPLETE (PARKED to OPEN) is taken when a response is present and writeback can take it. In every other case the machine stays in its current state.

Top module: `exu_stage`

## Requirements
- R1: While a load is parked, in_ready is low and mc_valid is low. The response is taken (mr_ready high) exactly when writeback is ready, and the parked load is presented to writeback with mr_valid as its valid.
- R2: With the slot empty, an instruction is accepted only when wb_ready and mc_ready are both high. An accepted non-load appears on writeback in the same cycle, with its tag, opcode, operands and next PC.
- R3: Jump-if-zero (opcode 4) yields operand A when operand B is zero, and otherwise yields the next PC.
- R4: Jump-if-nonzero (opcode 5) yields operand A when operand B is nonzero, and otherwise yields the next PC.
- R5: Add (opcode 0) and emit (opcode 1) both yield A + B, modulo 2^64.
- R6: A load (opcode 2) raises mc_valid in the cycle it is accepted. The command carries mc_line = (A + B) >> 6 (64-byte lines) and mc_write = 0. No other opcode raises mc_valid.
- R7: A load is not presented to writeback in its issue cycle. It reaches writeback only after a response arrives, and at most one load is outstanding at a time.
- R8: The load result is built from line bytes off .. off+7, where off = (A + B) & 63. Byte k of the line sits at mr_data[8k+7:8k], and line byte off+i becomes result bits [8i+7:8i]. Offsets above 56 are not supported.
- R9: Store (opcode 3) and the unused codes 6 and 7 pass to writeback with their operands unchanged and a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | 3 | Opcode |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_npc | input | 64 | Sequential next PC |
| in_tag | input | 8 | Instruction tag |
| wb_valid | output | 1 | Writeback item present |
| wb_ready | input | 1 | Writeback can accept |
| wb_op | output | 3 | Opcode of writeback item |
| wb_a | output | 64 | Operand A of writeback item |
| wb_b | output | 64 | Operand B of writeback item |
| wb_npc | output | 64 | Next PC of writeback item |
| wb_tag | output | 8 | Tag of writeback item |
| wb_result | output | 64 | Computed result |
| mc_valid | output | 1 | Memory command present |
| mc_ready | input | 1 | Memory can take a command |
| mc_line | output | 58 | Line address of the read |
| mc_write | output | 1 | Write flag, always zero here |
| mr_valid | input | 1 | Line response present |
| mr_ready | output | 1 | Line response taken |
| mr_data | input | 512 | Returned line, byte 0 in the low bits |

## Verification
The assertions assume that memory raises mr_valid only after it has received a load command, and that it holds mr_valid and mr_data steady until the response is taken. They also assume that every load offset is 56 or less. The bench's memory responder returns one line for each accepted command, after a latency of zero to three cycles, and keeps that line steady until mr_ready is seen. The bench adjusts operand B of every load so that the summed address lands at an offset no greater than 56.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_EMIT  = 3'd1,
        OPC_LOAD  = 3'd2,
        OPC_STORE = 3'd3,
        OPC_JZ    = 3'd4,
        OPC_JNZ   = 3'd5
    } opc_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_PARKED = 1'b1
    } exu_state_e;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] result,
    output logic            is_load
);

    logic b_zero;
    assign b_zero  = (b == '0);
    assign is_load = (op == OPC_LOAD);

    always_comb begin
        result = '0;
        unique case (op)
            OPC_ADD, OPC_EMIT: result = a + b;
            OPC_JZ:            result = b_zero ? a : npc;
            OPC_JNZ:           result = b_zero ? npc : a;
            default:           result = '0;
        endcase
    end

endmodule

// File: rtl/exu_line_pick.sv
module exu_line_pick #(
    parameter int XLEN       = 64,
    parameter int LINE_BYTES = 64
) (
    input  logic [LINE_BYTES*8-1:0]       line,
    input  logic [$clog2(LINE_BYTES)-1:0] off,
    output logic [XLEN-1:0]               word
);

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int WORD_BYTES = XLEN / 8;
    localparam int POS_W      = OFF_W + 4;

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
        logic [OFF_W:0] idx;
        logic [POS_W-1:0] pos;
        assign idx = {1'b0, off} + (OFF_W+1)'(k);
        assign pos = {1'b0, idx, 3'b000};
        assign word[8*k +: 8] = (idx < (OFF_W+1)'(LINE_BYTES)) ? line[pos +: 8] : 8'h00;
    end

endmodule

// File: rtl/exu_park_slot.sv
module exu_park_slot #(
    parameter int XLEN  = 64,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [2:0]       d_op,
    input  logic [XLEN-1:0]  d_a,
    input  logic [XLEN-1:0]  d_b,
    input  logic [XLEN-1:0]  d_npc,
    input  logic [TAG_W-1:0] d_tag,
    output logic [2:0]       q_op,
    output logic [XLEN-1:0]  q_a,
    output logic [XLEN-1:0]  q_b,
    output logic [XLEN-1:0]  q_npc,
    output logic [TAG_W-1:0] q_tag
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op  <= '0;
            q_a   <= '0;
            q_b   <= '0;
            q_npc <= '0;
            q_tag <= '0;
        end else if (capture) begin
            q_op  <= d_op;
            q_a   <= d_a;
            q_b   <= d_b;
            q_npc <= d_npc;
            q_tag <= d_tag;
        end
    end

endmodule

// File: rtl/exu_stage.sv
module exu_stage
    import exu_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [2:0]                          in_op,
    input  logic [XLEN-1:0]                     in_a,
    input  logic [XLEN-1:0]                     in_b,
    input  logic [XLEN-1:0]                     in_npc,
    input  logic [TAG_W-1:0]                    in_tag,
    output logic                                wb_valid,
    input  logic                                wb_ready,
    output logic [2:0]                          wb_op,
    output logic [XLEN-1:0]                     wb_a,
    output logic [XLEN-1:0]                     wb_b,
    output logic [XLEN-1:0]                     wb_npc,
    output logic [TAG_W-1:0]                    wb_tag,
    output logic [XLEN-1:0]                     wb_result,
    output logic                                mc_valid,
    input  logic                                mc_ready,
    output logic [XLEN-$clog2(LINE_BYTES)-1:0]  mc_line,
    output logic                                mc_write,
    input  logic                                mr_valid,
    output logic                                mr_ready,
    input  logic [LINE_BYTES*8-1:0]             mr_data
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    exu_state_e state, state_nx;

    logic [XLEN-1:0]  alu_res;
    logic             in_is_load;
    logic [XLEN-1:0]  in_addr;
    logic             issue;

    logic [2:0]       pk_op;
    logic [XLEN-1:0]  pk_a, pk_b, pk_npc;
    logic [TAG_W-1:0] pk_tag;
    logic [XLEN-1:0]  pk_addr;
    logic [XLEN-1:0]  pk_word;

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op      (in_op),
        .a       (in_a),
        .b       (in_b),
        .npc     (in_npc),
        .result  (alu_res),
        .is_load (in_is_load)
    );

    exu_park_slot #(.XLEN(XLEN), .TAG_W(TAG_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (issue),
        .d_op    (in_op),
        .d_a     (in_a),
        .d_b     (in_b),
        .d_npc   (in_npc),
        .d_tag   (in_tag),
        .q_op    (pk_op),
        .q_a     (pk_a),
        .q_b     (pk_b),
        .q_npc   (pk_npc),
        .q_tag   (pk_tag)
    );

    assign pk_addr = pk_a + pk_b;

    exu_line_pick #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_pick (
        .line (mr_data),
        .off  (pk_addr[OFF_W-1:0]),
        .word (pk_word)
    );

    assign in_addr  = in_a + in_b;
    assign mc_line  = in_addr[XLEN-1:OFF_W];
    assign mc_write = 1'b0;
    assign issue    = (state == ST_OPEN) && in_valid && in_ready && in_is_load;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nx;
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        in_ready  = 1'b0;
        mc_valid  = 1'b0;
        mr_ready  = 1'b0;
        wb_valid  = 1'b0;
        wb_op     = in_op;
        wb_a      = in_a;
        wb_b      = in_b;
        wb_npc    = in_npc;
        wb_tag    = in_tag;
        wb_result = alu_res;
        unique case (state)
            ST_OPEN: begin
                in_ready = wb_ready && mc_ready;
                mc_valid = in_valid && in_is_load && wb_ready;
                wb_valid = in_valid && !in_is_load && mc_ready;
                if (in_valid && in_ready && in_is_load) state_nx = ST_PARKED; // ISSUE
            end
            ST_PARKED: begin
                mr_ready  = wb_ready;
                wb_valid  = mr_valid;
                wb_op     = pk_op;
                wb_a      = pk_a;
                wb_b      = pk_b;
                wb_npc    = pk_npc;
                wb_tag    = pk_tag;
                wb_result = pk_word;
                if (mr_valid && wb_ready) state_nx = ST_OPEN;                  // COMPLETE
            end
            default: state_nx = ST_OPEN;
        endcase
    end

endmodule

// File: rtl/exu_stage_chk.sv
module exu_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic wb_valid,
    input logic wb_ready,
    input logic mc_valid,
    input logic mc_ready,
    input logic mc_write,
    input logic mr_ready
);

    // R1: the cycle after a load command is taken, no new instruction is accepted
    p_park_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_valid && mc_ready) |=> !in_ready);

    // R1: taking a response excludes new work and new commands
    p_resp_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mr_ready |-> (!in_ready && !mc_valid));

    // R2: an accepted instruction leaves on exactly one channel that same cycle
    p_accept_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> $onehot0({wb_valid && wb_ready, mc_valid && mc_ready})
                                   && (wb_valid || mc_valid));

    // R6: the command channel only ever reads
    p_cmd_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mc_valid |-> !mc_write);

    // R7: a load is never forwarded to writeback in its issue cycle
    p_no_early_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mc_valid |-> !wb_valid);

endmodule

bind exu_stage exu_stage_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wb_valid (wb_valid),
    .wb_ready (wb_ready),
    .mc_valid (mc_valid),
    .mc_ready (mc_ready),
    .mc_write (mc_write),
    .mr_ready (mr_ready)
);

// File: tb/exu_stage_tb.sv
`timescale 1ns/1ps
module exu_stage_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_op = '0;
    logic [63:0]  in_a = '0, in_b = '0, in_npc = '0;
    logic [7:0]   in_tag = '0;
    logic         wb_valid;
    logic         wb_ready = 1'b0;
    logic [2:0]   wb_op;
    logic [63:0]  wb_a, wb_b, wb_npc, wb_result;
    logic [7:0]   wb_tag;
    logic         mc_valid;
    logic         mc_ready = 1'b0;
    logic [57:0]  mc_line;
    logic         mc_write;
    logic         mr_valid = 1'b0;
    logic         mr_ready;
    logic [511:0] mr_data = '0;

    int checks = 0;
    int fails  = 0;
    bit auto_rdy = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0]  op;
        logic [7:0]  tag;
        logic [63:0] a, b, res;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    exu_stage u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .in_npc(in_npc), .in_tag(in_tag),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_op(wb_op), .wb_a(wb_a), .wb_b(wb_b),
        .wb_npc(wb_npc), .wb_tag(wb_tag), .wb_result(wb_result),
        .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_line(mc_line), .mc_write(mc_write),
        .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_data(mr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [57:0] line, input int i);
        return 8'(line[7:0] * 8'd29 + 8'(i) * 8'd7 + 8'h3c);
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] npc);
        logic [63:0] addr;
        logic [63:0] r;
        r = '0;
        addr = a + b;
        case (op)
            3'd0, 3'd1: r = a + b;
            3'd4: r = (b == 0) ? a : npc;
            3'd5: r = (b != 0) ? a : npc;
            3'd2: for (int k = 0; k < 8; k++)
                      r[8*k +: 8] = mem_byte(addr[63:6], int'(addr[5:0]) + k);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R5";
            3'd2: return "R8";
            3'd4: return "R3";
            3'd5: return "R4";
            default: return "R9";
        endcase
    endfunction

    // driver: call at a falling edge, returns at a falling edge after acceptance
    task automatic send(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] npc, input logic [7:0] tag);
        bit acc;
        exp_t e;
        logic [63:0] addr;
        acc = 1'b0;
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_npc = npc; in_tag = tag;
        while (!acc) begin
            #2;
            if (in_ready) begin
                acc = 1'b1;
                if (op == 3'd2) begin
                    addr = a + b;
                    chk(mc_valid && mc_line == addr[63:6] && !mc_write, "R6",
                        {5'd0, mc_write, mc_line}, {6'd0, addr[63:6]});
                    chk(!wb_valid, "R7", {63'd0, wb_valid}, 64'd0);
                end else begin
                    chk(!mc_valid, "R6", {63'd0, mc_valid}, 64'd0);
                end
                e.op = op; e.tag = tag; e.a = a; e.b = b;
                e.res = model(op, a, b, npc); e.req = req_of(op);
                sb.push_back(e);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && wb_valid && wb_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", {56'd0, wb_tag}, 64'd0);
                end else begin
                    e = sb.pop_front();
                    chk(wb_result == e.res, e.req, wb_result, e.res);
                    chk(wb_tag == e.tag && wb_op == e.op, "R2", {53'd0, wb_op, wb_tag}, {53'd0, e.op, e.tag});
                    if (e.req == "R9")
                        chk(wb_a == e.a && wb_b == e.b, "R9", wb_a ^ wb_b, e.a ^ e.b);
                end
            end
        end
    end

    // memory responder
    initial begin
        bit pend = 1'b0, taken = 1'b0;
        int dly = 0;
        logic [57:0] ln = '0;
        forever begin
            @(negedge clk);
            if (taken) begin mr_valid = 1'b0; taken = 1'b0; end
            if (pend && !mr_valid) begin
                if (dly == 0) begin
                    mr_valid = 1'b1;
                    for (int i = 0; i < 64; i++) mr_data[8*i +: 8] = mem_byte(ln, i);
                end else dly--;
            end
            #2;
            if (mr_valid && mr_ready) begin taken = 1'b1; pend = 1'b0; end
            if (mc_valid && mc_ready) begin
                pend = 1'b1; ln = mc_line; dly = int'($urandom % 4);
            end
        end
    end

    // ready pattern for the mixed phase
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rdy) begin
                wb_ready = ($urandom % 4) != 0;
                mc_ready = ($urandom % 3) != 0;
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] a, b;
        logic [2:0] op;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!wb_valid && !mc_valid && !mr_ready && !in_ready, "R2",
            {60'd0, wb_valid, mc_valid, mr_ready, in_ready}, 64'd0);
        @(negedge clk);
        wb_ready = 1'b1; mc_ready = 1'b1;

        send(3'd0, 64'h0000_0001_0000_0005, 64'h10, 64'h100, 8'd1);        // R5 add
        send(3'd1, 64'hffff_ffff_ffff_ffff, 64'h2, 64'h104, 8'd2);         // R5 emit wraps
        send(3'd4, 64'h4000, 64'd0, 64'h108, 8'd3);                        // R3 taken
        send(3'd4, 64'h4000, 64'd5, 64'h10c, 8'd4);                        // R3 not taken
        send(3'd5, 64'h5000, 64'd3, 64'h110, 8'd5);                        // R4 taken
        send(3'd5, 64'h5000, 64'd0, 64'h114, 8'd6);                        // R4 not taken
        send(3'd3, 64'hdead_0000_0000_0040, 64'h1234_5678, 64'h118, 8'd7); // R9 store
        send(3'd7, 64'h77, 64'h88, 64'h11c, 8'd8);                         // R9 unused code

        // R2: no acceptance when either downstream channel is blocked
        mc_ready = 1'b0;
        in_valid = 1'b1; in_op = 3'd0; in_a = 64'd1; in_b = 64'd2; in_tag = 8'd9;
        #2;
        chk(!in_ready && !wb_valid, "R2", {62'd0, in_ready, wb_valid}, 64'd0);
        @(negedge clk);
        mc_ready = 1'b1; wb_ready = 1'b0;
        #2;
        chk(!in_ready, "R2", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        wb_ready = 1'b1;
        send(3'd0, 64'd1, 64'd2, 64'h120, 8'd9);

        // R8 loads at several offsets
        send(3'd2, 64'h1000, 64'd0,  64'h124, 8'd10);
        send(3'd2, 64'h2000, 64'd5,  64'h128, 8'd11);
        send(3'd2, 64'h3030, 64'd8,  64'h12c, 8'd12);
        send(3'd2, 64'h4000, 64'd17, 64'h130, 8'd13);

        // R1: parked load blocks a waiting add and waits for writeback space
        send(3'd2, 64'h5000, 64'd9, 64'h134, 8'd14);
        wb_ready = 1'b0;
        in_valid = 1'b1; in_op = 3'd0; in_a = 64'd3; in_b = 64'd4; in_npc = 64'h138; in_tag = 8'd15;
        #2;
        while (!mr_valid) begin
            chk(!in_ready && !mc_valid, "R1", {62'd0, in_ready, mc_valid}, 64'd0);
            @(negedge clk);
            #2;
        end
        chk(!mr_ready && !in_ready, "R1", {62'd0, mr_ready, in_ready}, 64'd0);
        @(negedge clk);
        wb_ready = 1'b1;
        #2;
        chk(mr_ready && wb_valid && !in_ready && wb_tag == 8'd14, "R1",
            {53'd0, mr_ready, wb_valid, in_ready, wb_tag}, {53'd0, 3'b110, 8'd14});
        @(negedge clk);
        send(3'd0, 64'd3, 64'd4, 64'h138, 8'd15);

        // mixed traffic with random backpressure
        auto_rdy = 1'b1;
        for (int n = 0; n < 60; n++) begin
            op = 3'($urandom % 8);
            a = {$urandom, $urandom};
            b = ($urandom % 2) ? 64'd0 : {$urandom, $urandom};
            if (op == 3'd2 && ((a + b) & 64'h3f) > 64'd56) b = b - 64'd8;
            send(op, a, b, 64'h2000 + 64'(n * 4), 8'(n + 16));
            if ($urandom % 3 == 0) @(negedge clk);
        end
        auto_rdy = 1'b0;
        wb_ready = 1'b1;
        repeat (20) @(negedge clk);
        chk(sb.size() == 0, "R7", 64'(sb.size()), 64'd0);
        finish_run();
    end

endmodule